// File: doc/BRIEF.md
# Tiled Sprite Raster Generator

This block produces a 640x480 raster at a 25 MHz pixel clock and paints the whole visible area with one 32x32 picture, repeated as tiles. The picture sits in an on-block synchronous-read store of 1024 words of 12 bits. A fixed pattern function fills the store when it is built. The store address for each pixel is taken straight from the low five bits of the row and column counters, so no multiplier or divider is needed.

The store answers one clock after the address is presented. For that reason the two sync strobes and the visible-area flag pass through one register stage of the same depth, so colour and sync leave the block on the same edge. Colour is forced to black whenever the delayed visible flag is low. All raster geometry, the tile size and the channel width are parameters. The defaults give the standard 640x480 frame of 800 by 525 clocks.

Top module: `tile_vga_top`

## Requirements
- R1: The column counter steps by one every clock from 0 to 799, then returns to 0, so hsync falls exactly every 800 clocks.
- R2: The row counter changes only when the column counter wraps from 799 to 0, and it returns to 0 after 524, so a frame lasts 800x525 clocks.
- R3: hsync is low for the pixel slots whose column is 656 to 751 inclusive, and high for all other columns.
- R4: vsync is low for the pixel slots whose row is 490 or 491, and high for all other rows.
- R5: A visible pixel at (column c, row r) carries picture word W = store[(r mod 32)*32 + (c mod 32)]. red is W[11:8], green is W[7:4] and blue is W[3:0]. The built-in picture holds, for tile row y and tile column x: red = y/2, green = x/2, blue = 15 - ((x xor y) mod 16).
- R6: Every output belongs to the pixel slot whose counters were present one clock earlier. hsync, vsync and colour change on the same edge.
- R7: red, green and blue are all zero for any slot with column 640 or more, or with row 480 or more.
- R8: While the synchronous reset is high, both counters hold 0, hsync and vsync are high and the colours are zero. The first clock edge after reset is released emits the slot at column 0, row 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, 25 MHz by default |
| rst | input | 1 | Synchronous reset, active high |
| hsync | output | 1 | Line sync, active low |
| vsync | output | 1 | Frame sync, active low |
| red | output | 4 | Red channel |
| green | output | 4 | Green channel |
| blue | output | 4 | Blue channel |

## Verification
The assertions check on every cycle the counter stepping and wrapping, the row hold between line ends, the placement of each sync strobe one clock after its counter window, the blanking of colour outside the visible area, and the reset state. The tile contents cannot be seen from properties. Only the bench scenarios show them: they compare every visible pixel against an independently computed picture word, check the sync and colour alignment at tile edges and at visible-area edges, and check the line and frame periods. A reduced-geometry instance lets whole frames, including the vsync pulse and the row wrap, run within the bench's cycle budget.

// File: rtl/tile_vga_pkg.sv
package tile_vga_pkg;

  localparam int CHAN_W = 4;
  localparam int PIX_W  = 3 * CHAN_W;

  typedef logic [PIX_W-1:0] pix_t;

  // Channel order inside a picture word: red in the top bits, blue at the bottom.
  typedef struct packed {
    logic [CHAN_W-1:0] red;
    logic [CHAN_W-1:0] green;
    logic [CHAN_W-1:0] blue;
  } rgb_t;

  // Built-in picture: red follows the tile row, green the tile column,
  // blue an inverted xor checker.
  function automatic pix_t tile_pattern(input int unsigned row, input int unsigned col);
    logic [CHAN_W-1:0] r, g, b;
    int unsigned mix;
    r   = CHAN_W'(row >> 1);
    g   = CHAN_W'(col >> 1);
    mix = row ^ col;
    b   = ~CHAN_W'(mix);
    return {r, g, b};
  endfunction

  // True when value lies in [first, first+len).
  function automatic logic in_span(input int unsigned value, input int unsigned first,
                                   input int unsigned len);
    return (value >= first) && (value < first + len);
  endfunction

endpackage

// File: rtl/tile_vga_scan.sv
module tile_vga_scan #(
  parameter int H_TOTAL = 800,
  parameter int V_TOTAL = 525,
  parameter int HW      = $clog2(H_TOTAL),
  parameter int VW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output logic          line_end,
  output logic          frame_end
);

  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  assign line_end  = (h_cnt == H_LAST);
  assign frame_end = line_end && (v_cnt == V_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else begin
      h_cnt <= line_end ? '0 : h_cnt + 1'b1;
      if (frame_end)
        v_cnt <= '0;
      else if (line_end)
        v_cnt <= v_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/tile_vga_rom.sv
module tile_vga_rom
  import tile_vga_pkg::*;
#(
  parameter int TILE_BITS = 5
) (
  input  logic                   clk,
  input  logic [2*TILE_BITS-1:0] addr,
  output pix_t                   data
);

  localparam int SIDE  = 1 << TILE_BITS;
  localparam int DEPTH = SIDE * SIDE;

  pix_t store [DEPTH];

  initial begin
    for (int unsigned i = 0; i < DEPTH; i++)
      store[i] = tile_pattern(i >> TILE_BITS, i & (SIDE - 1));
  end

  always_ff @(posedge clk)
    data <= store[addr];

endmodule

// File: rtl/tile_vga_align.sv
module tile_vga_align
  import tile_vga_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_raw,
  input  logic              vs_raw,
  input  logic              vis_raw,
  input  pix_t              pix,
  output logic              hsync,
  output logic              vsync,
  output logic [CHAN_W-1:0] red,
  output logic [CHAN_W-1:0] green,
  output logic [CHAN_W-1:0] blue
);

  logic vis_q;
  rgb_t shown;

  // One stage, matching the store's read latency.
  always_ff @(posedge clk) begin
    if (rst) begin
      hsync <= 1'b1;
      vsync <= 1'b1;
      vis_q <= 1'b0;
    end else begin
      hsync <= hs_raw;
      vsync <= vs_raw;
      vis_q <= vis_raw;
    end
  end

  assign shown = vis_q ? rgb_t'(pix) : '0;
  assign red   = shown.red;
  assign green = shown.green;
  assign blue  = shown.blue;

endmodule

// File: rtl/tile_vga_top.sv
module tile_vga_top
  import tile_vga_pkg::*;
#(
  parameter int H_ACTIVE  = 640,
  parameter int H_FRONT   = 16,
  parameter int H_SYNC    = 96,
  parameter int H_BACK    = 48,
  parameter int V_ACTIVE  = 480,
  parameter int V_FRONT   = 10,
  parameter int V_SYNC    = 2,
  parameter int V_BACK    = 33,
  parameter int TILE_BITS = 5
) (
  input  logic              clk,
  input  logic              rst,
  output logic              hsync,
  output logic              vsync,
  output logic [CHAN_W-1:0] red,
  output logic [CHAN_W-1:0] green,
  output logic [CHAN_W-1:0] blue
);

  localparam int H_TOTAL  = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL  = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int HW       = $clog2(H_TOTAL);
  localparam int VW       = $clog2(V_TOTAL);
  localparam int HS_START = H_ACTIVE + H_FRONT;
  localparam int VS_START = V_ACTIVE + V_FRONT;

  // Named internal events, also watched by the bound checker.
  logic [HW-1:0]          h_cnt;
  logic [VW-1:0]          v_cnt;
  logic                   line_end;
  logic                   frame_end;
  logic                   hs_zone;
  logic                   vs_zone;
  logic                   vis_now;
  logic [2*TILE_BITS-1:0] rom_addr;
  pix_t                   rom_word;

  tile_vga_scan #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .HW(HW), .VW(VW)
  ) u_scan (
    .clk(clk), .rst(rst), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .line_end(line_end), .frame_end(frame_end)
  );

  assign hs_zone  = in_span(32'(h_cnt), HS_START, H_SYNC);
  assign vs_zone  = in_span(32'(v_cnt), VS_START, V_SYNC);
  assign vis_now  = (32'(h_cnt) < H_ACTIVE) && (32'(v_cnt) < V_ACTIVE);
  assign rom_addr = {v_cnt[TILE_BITS-1:0], h_cnt[TILE_BITS-1:0]};

  tile_vga_rom #(.TILE_BITS(TILE_BITS)) u_rom (
    .clk(clk), .addr(rom_addr), .data(rom_word)
  );

  tile_vga_align u_align (
    .clk(clk), .rst(rst),
    .hs_raw(!hs_zone), .vs_raw(!vs_zone), .vis_raw(vis_now), .pix(rom_word),
    .hsync(hsync), .vsync(vsync), .red(red), .green(green), .blue(blue)
  );

endmodule

// File: rtl/tile_vga_checks.sv
module tile_vga_checks #(
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 33,
  parameter int CW       = 4
) (
  input logic                                                       clk,
  input logic                                                       rst,
  input logic [$clog2(H_ACTIVE+H_FRONT+H_SYNC+H_BACK)-1:0]          h_cnt,
  input logic [$clog2(V_ACTIVE+V_FRONT+V_SYNC+V_BACK)-1:0]          v_cnt,
  input logic                                                       line_end,
  input logic                                                       hsync,
  input logic                                                       vsync,
  input logic [CW-1:0]                                              red,
  input logic [CW-1:0]                                              green,
  input logic [CW-1:0]                                              blue
);

  localparam int H_MAX = H_ACTIVE + H_FRONT + H_SYNC + H_BACK - 1;
  localparam int V_MAX = V_ACTIVE + V_FRONT + V_SYNC + V_BACK - 1;
  localparam int HS_LO = H_ACTIVE + H_FRONT;
  localparam int VS_LO = V_ACTIVE + V_FRONT;

  int unsigned h, v;
  assign h = 32'(h_cnt);
  assign v = 32'(v_cnt);

  assert_h_range_R1: assert property (@(posedge clk) disable iff (rst) h <= H_MAX);

  assert_h_step_R1: assert property (@(posedge clk) disable iff (rst)
    (h != H_MAX) |=> (h == $past(h) + 1));

  assert_h_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (h == H_MAX) |=> (h == 0));

  assert_v_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> $stable(v_cnt));

  assert_v_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (h == H_MAX && v == V_MAX) |=> (v == 0));

  assert_hsync_low_R3: assert property (@(posedge clk) disable iff (rst)
    (h >= HS_LO && h < HS_LO + H_SYNC) |=> !hsync);

  assert_hsync_high_R3: assert property (@(posedge clk) disable iff (rst)
    !(h >= HS_LO && h < HS_LO + H_SYNC) |=> hsync);

  assert_vsync_low_R4: assert property (@(posedge clk) disable iff (rst)
    (v >= VS_LO && v < VS_LO + V_SYNC) |=> !vsync);

  assert_vsync_high_R4: assert property (@(posedge clk) disable iff (rst)
    !(v >= VS_LO && v < VS_LO + V_SYNC) |=> vsync);

  assert_blank_R7: assert property (@(posedge clk) disable iff (rst)
    (h >= H_ACTIVE || v >= V_ACTIVE) |=> ({red, green, blue} == '0));

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (h == 0 && v == 0 && hsync && vsync && {red, green, blue} == '0));

endmodule

bind tile_vga_top tile_vga_checks #(
  .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
  .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK),
  .CW(tile_vga_pkg::CHAN_W)
) u_checks (
  .clk(clk), .rst(rst), .h_cnt(h_cnt), .v_cnt(v_cnt), .line_end(line_end),
  .hsync(hsync), .vsync(vsync), .red(red), .green(green), .blue(blue)
);

// File: tb/test_tile_vga_top.sv
module test_tile_vga_top;

  localparam int CLK_PERIOD = 40;
  localparam int WATCHDOG   = 195000;
  localparam int MAIN_RUN   = 170000;

  // Full geometry (instance A) and a reduced one (instance B).
  localparam int A_HT = 800, A_VT = 525, A_HV = 640, A_VV = 480;
  localparam int A_HS = 656, A_HE = 752, A_VS = 490, A_VE = 492;
  localparam int B_HT = 60,  B_VT = 30,  B_HV = 40,  B_VV = 20;
  localparam int B_HS = 44,  B_HE = 50,  B_VS = 23,  B_VE = 25;

  // Directed points on instance A: column, row, expected hsync, visible.
  localparam int NPTS = 12;
  localparam int PTS [NPTS][4] = '{
    '{0, 0, 1, 1}, '{31, 0, 1, 1}, '{32, 0, 1, 1}, '{639, 0, 1, 1},
    '{640, 0, 1, 0}, '{655, 1, 1, 0}, '{656, 1, 0, 0}, '{751, 2, 0, 0},
    '{752, 2, 1, 0}, '{799, 3, 1, 0}, '{33, 31, 1, 1}, '{100, 200, 1, 1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_hs, a_vs, b_hs, b_vs;
  logic [3:0] a_r, a_g, a_b, b_r, b_g, b_b;

  int unsigned cyc = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_vga_top i_tile_vga_top (
    .clk(clk), .rst(rst), .hsync(a_hs), .vsync(a_vs), .red(a_r), .green(a_g), .blue(a_b)
  );

  tile_vga_top #(
    .H_ACTIVE(40), .H_FRONT(4), .H_SYNC(6), .H_BACK(10),
    .V_ACTIVE(20), .V_FRONT(3), .V_SYNC(2), .V_BACK(5)
  ) i_tile_vga_top_small (
    .clk(clk), .rst(rst), .hsync(b_hs), .vsync(b_vs), .red(b_r), .green(b_g), .blue(b_b)
  );

  // Picture word restated from R5 as integer arithmetic.
  function automatic int picture(input int col, input int row);
    int y, x;
    y = row % 32;
    x = col % 32;
    return (y / 2) * 256 + (x / 2) * 16 + (15 - ((x ^ y) % 16));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  // Per-slot scoreboard for both instances.
  int p, ha, va, hb, vb, exp_w;
  always @(negedge clk) begin
    if (mon_on) begin
      if (cyc == 0) begin
        check(a_hs === 1'b1 && a_vs === 1'b1, "R8", "sync idle in reset", {a_hs, a_vs}, 3);
        check({a_r, a_g, a_b} === 12'd0, "R8", "black in reset", {a_r, a_g, a_b}, 0);
        check(b_hs === 1'b1 && b_vs === 1'b1, "R8", "small sync idle in reset", {b_hs, b_vs}, 3);
      end else begin
        p  = int'(cyc) - 1;
        ha = p % A_HT;
        va = (p / A_HT) % A_VT;
        check(a_hs === !(ha >= A_HS && ha < A_HE), "R3", "hsync", a_hs, !(ha >= A_HS && ha < A_HE));
        check(a_vs === !(va >= A_VS && va < A_VE), "R4", "vsync", a_vs, !(va >= A_VS && va < A_VE));
        if (ha < A_HV && va < A_VV) begin
          exp_w = picture(ha, va);
          check({a_r, a_g, a_b} === 12'(exp_w), "R5", "tile pixel", {a_r, a_g, a_b}, exp_w);
        end else
          check({a_r, a_g, a_b} === 12'd0, "R7", "blanking", {a_r, a_g, a_b}, 0);
        hb = p % B_HT;
        vb = (p / B_HT) % B_VT;
        check(b_hs === !(hb >= B_HS && hb < B_HE), "R3", "small hsync", b_hs, !(hb >= B_HS && hb < B_HE));
        check(b_vs === !(vb >= B_VS && vb < B_VE), "R4", "small vsync", b_vs, !(vb >= B_VS && vb < B_VE));
        exp_w = (hb < B_HV && vb < B_VV) ? picture(hb, vb) : 0;
        check({b_r, b_g, b_b} === 12'(exp_w), "R5", "small pixel or blank", {b_r, b_g, b_b}, exp_w);
      end
    end
  end

  // Period measurement on falling sync edges.
  logic a_hs_prev = 1'b1, b_hs_prev = 1'b1, b_vs_prev = 1'b1;
  int unsigned a_hfall, b_hfall, b_vfall;
  bit a_hv = 1'b0, b_hv = 1'b0, b_vv = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (cyc == 0) begin
        a_hv = 1'b0; b_hv = 1'b0; b_vv = 1'b0;
      end else begin
        if (a_hs_prev && !a_hs) begin
          if (a_hv) check(cyc - a_hfall == A_HT, "R1", "line period", int'(cyc - a_hfall), A_HT);
          a_hfall = cyc; a_hv = 1'b1;
        end
        if (b_hs_prev && !b_hs) begin
          if (b_hv) check(cyc - b_hfall == B_HT, "R1", "small line period", int'(cyc - b_hfall), B_HT);
          b_hfall = cyc; b_hv = 1'b1;
        end
        if (b_vs_prev && !b_vs) begin
          if (b_vv) check(cyc - b_vfall == B_HT * B_VT, "R2", "frame period",
                          int'(cyc - b_vfall), B_HT * B_VT);
          b_vfall = cyc; b_vv = 1'b1;
        end
      end
      a_hs_prev = a_hs; b_hs_prev = b_hs; b_vs_prev = b_vs;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) mon_on = 1'b1;
    @(negedge clk) rst = 1'b0;

    // R6: sync and colour of a slot appear together one clock after its counters.
    for (int k = 0; k < NPTS; k++) begin
      int tgt;
      tgt = PTS[k][1] * A_HT + PTS[k][0] + 1;
      while (int'(cyc) != tgt) @(negedge clk);
      check(a_hs === 1'(PTS[k][2]), "R6", "aligned hsync", a_hs, PTS[k][2]);
      exp_w = PTS[k][3] != 0 ? picture(PTS[k][0], PTS[k][1]) : 0;
      check({a_r, a_g, a_b} === 12'(exp_w), "R6", "aligned colour", {a_r, a_g, a_b}, exp_w);
    end

    while (cyc < MAIN_RUN) @(negedge clk);

    // R8: reset mid-line, then the first slot after release is column 0, row 0.
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({a_r, a_g, a_b} === 12'(picture(0, 0)), "R8", "first slot after reset",
          {a_r, a_g, a_b}, picture(0, 0));
    check(a_hs === 1'b1 && a_vs === 1'b1, "R8", "syncs after reset", {a_hs, a_vs}, 3);
    repeat (2000) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule